// File: doc/BRIEF.md
# Clock Divider Setting Calculator

This block turns a parent clock frequency and a requested output frequency, both 32-bit unsigned values, into the settings for a two-stage clock divider: a 10-bit pre-divider followed by a 6-bit final divider. It finds the integer division ratio that lands nearest to the requested frequency. It places the whole ratio in one stage and leaves the other stage at divide-by-one. It also reports the frequency that the chosen ratio actually produces.

A request is launched with a one-cycle `start` pulse. The block runs two 32-step restoring divisions, one bit per clock. The first finds the ratio and the second finds the achieved frequency. The results appear on the outputs together with a one-cycle `done` pulse. When control mode is requested, the block pulses `syncClear` before it commits the new values, so that the surrounding logic can drop the divider's synchronous-mode bit ahead of the update. Writing the settings into the divider hardware and changing the parent clock are left to the surrounding logic.

Top module: `clkDivCalc`

## Requirements
- R1: The ratio is floor(parent / target). One is added to it unless target > 2 * (parent mod target).
- R2: When the ratio is 64 or less, `finField` carries ratio minus one and `preField` is 0. A field value v means divide by v+1.
- R3: When the ratio is above 64, `preField` carries ratio minus one and `finField` is 0.
- R4: A ratio that works out to zero is treated as a ratio of one, which makes both fields 0.
- R5: A ratio above 1024 is clamped to 1024 (`preField` = 1023) and `satFlag` is set. A ratio of exactly 1024 leaves `satFlag` clear. `satFlag` is updated on every completed calculation.
- R6: `achievedFreq` equals floor(parent / ratio), where ratio is the value after rounding, forcing and clamping.
- R7: A start with a target of zero sets `errZero`, pulses `done` on the next cycle, and leaves `preField`, `finField`, `achievedFreq` and `satFlag` unchanged. The next valid start clears `errZero`.
- R8: When `ctrlMode` is high at start, `syncClear` is high for exactly one cycle, two cycles before `done`. When `ctrlMode` is low at start, `syncClear` stays low.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start until `done`. A start that arrives while `busy` is high is ignored.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a calculation when the block is idle |
| parentFreq | input | 32 | Parent clock frequency |
| targetFreq | input | 32 | Requested output frequency |
| ctrlMode | input | 1 | Asks for a sync-clear pulse ahead of the commit |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle pulse: the results are valid |
| syncClear | output | 1 | One-cycle pulse: clear the synchronous-mode bit now |
| errZero | output | 1 | The last start had a zero target |
| satFlag | output | 1 | The last ratio was clamped to 1024 |
| preField | output | 10 | Pre-divider setting, ratio minus one |
| finField | output | 6 | Final divider setting, ratio minus one |
| achievedFreq | output | 32 | Parent frequency divided by the chosen ratio |

## Verification
The bench works through the rounding boundary, where a remainder of exactly half the target must round up. A design that compared with the wrong strictness would land one ratio too low. It also places ratios on both sides of the 64/65 split, where an off-by-one would send the ratio to the wrong stage, and on both sides of the 1024 clamp, where a wrong clamp would either wrap the 10-bit field or raise a false saturation. A target above twice the parent produces a raw ratio of zero; without the forcing rule the design would try to divide by zero in its second division. A zero target, a start issued mid-calculation, and the position of the sync pulse relative to `done` round out the cases. Each of these would show a corrupted result or a wrongly timed pulse if mishandled.

// File: rtl/clkDivCalcPkg.sv
package clkDivCalcPkg;
  typedef struct packed {
    logic loadFirst;   // latch operands for the ratio division
    logic step;        // advance the restoring divider one bit
    logic loadSecond;  // latch rounded ratio, start achieved-frequency division
    logic commit;      // move results to the outputs
  } dpCtrlT;
endpackage

// File: rtl/clkDivDatapath.sv
module clkDivDatapath
  import clkDivCalcPkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int PRE_W  = 10,
  parameter int FIN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctl,
  input  logic [FREQ_W-1:0] parentFreq,
  input  logic [FREQ_W-1:0] targetFreq,
  output logic              satFlag,
  output logic [PRE_W-1:0]  preField,
  output logic [FIN_W-1:0]  finField,
  output logic [FREQ_W-1:0] achievedFreq
);
  localparam int SPLIT = 2 ** FIN_W;
  localparam int MAXR  = 2 ** PRE_W;

  logic [FREQ_W-1:0] parentQ, divisorQ, quotQ, remQ;
  logic [PRE_W-1:0]  ratioM1Q;
  logic              satPendQ;

  // restoring divider step
  logic [FREQ_W:0]   trial;
  logic              fits;
  assign trial = {remQ, quotQ[FREQ_W-1]};
  assign fits  = trial >= {1'b0, divisorQ};

  // rounding, forcing and clamping of the ratio
  logic [FREQ_W:0]   twoRem, sum;
  logic              bump, satNext;
  logic [FREQ_W-1:0] ratioSel;
  logic [PRE_W-1:0]  ratioM1Next;

  always_comb begin
    twoRem   = {remQ, 1'b0};
    bump     = !({1'b0, divisorQ} > twoRem);
    sum      = {1'b0, quotQ} + {{FREQ_W{1'b0}}, bump};
    satNext  = 1'b0;
    if (sum == '0) begin
      ratioSel = FREQ_W'(1);
    end else if (sum > (FREQ_W+1)'(MAXR)) begin
      ratioSel = FREQ_W'(MAXR);
      satNext  = 1'b1;
    end else begin
      ratioSel = sum[FREQ_W-1:0];
    end
    ratioM1Next = PRE_W'(ratioSel - FREQ_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parentQ  <= '0;
      divisorQ <= '0;
      quotQ    <= '0;
      remQ     <= '0;
      ratioM1Q <= '0;
      satPendQ <= 1'b0;
    end else if (ctl.loadFirst) begin
      parentQ  <= parentFreq;
      divisorQ <= targetFreq;
      quotQ    <= parentFreq;
      remQ     <= '0;
    end else if (ctl.step) begin
      if (fits) remQ <= FREQ_W'(trial - {1'b0, divisorQ});
      else      remQ <= trial[FREQ_W-1:0];
      quotQ <= {quotQ[FREQ_W-2:0], fits};
    end else if (ctl.loadSecond) begin
      ratioM1Q <= ratioM1Next;
      satPendQ <= satNext;
      divisorQ <= ratioSel;
      quotQ    <= parentQ;
      remQ     <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      satFlag      <= 1'b0;
      preField     <= '0;
      finField     <= '0;
      achievedFreq <= '0;
    end else if (ctl.commit) begin
      satFlag      <= satPendQ;
      achievedFreq <= quotQ;
      if (ratioM1Q <= PRE_W'(SPLIT - 1)) begin
        finField <= ratioM1Q[FIN_W-1:0];
        preField <= '0;
      end else begin
        preField <= ratioM1Q;
        finField <= '0;
      end
    end
  end

  // R6
  achieved_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> achievedFreq <= parentQ);

  // R5
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> preField == PRE_W'(MAXR - 1));

  // R2
  one_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.commit) |-> (preField == '0 || finField == '0));
endmodule

// File: rtl/clkDivControl.sv
module clkDivControl
  import clkDivCalcPkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   targetZero,
  input  logic   ctrlMode,
  output dpCtrlT ctl,
  output logic   busy,
  output logic   done,
  output logic   syncClear,
  output logic   errZero
);
  localparam int CNT_W = $clog2(STEPS);

  typedef enum logic [2:0] {
    S_IDLE, S_FIRST, S_ROUND, S_SECOND, S_SYNC, S_APPLY
  } stateT;

  stateT             state;
  logic [CNT_W-1:0]  cnt;
  logic              modeQ;
  logic              lastStep;
  logic              accept;

  assign lastStep  = cnt == CNT_W'(STEPS - 1);
  assign accept    = (state == S_IDLE) && start;
  assign busy      = state != S_IDLE;
  assign syncClear = state == S_SYNC;

  always_comb begin
    ctl            = '0;
    ctl.loadFirst  = accept && !targetZero;
    ctl.step       = (state == S_FIRST) || (state == S_SECOND);
    ctl.loadSecond = state == S_ROUND;
    ctl.commit     = state == S_APPLY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      modeQ   <= 1'b0;
      done    <= 1'b0;
      errZero <= 1'b0;
    end else begin
      done <= (state == S_APPLY) || (accept && targetZero);
      case (state)
        S_IDLE: begin
          if (start) begin
            if (targetZero) begin
              errZero <= 1'b1;
            end else begin
              errZero <= 1'b0;
              modeQ   <= ctrlMode;
              cnt     <= '0;
              state   <= S_FIRST;
            end
          end
        end
        S_FIRST: begin
          cnt <= cnt + 1'b1;
          if (lastStep) state <= S_ROUND;
        end
        S_ROUND: begin
          cnt   <= '0;
          state <= S_SECOND;
        end
        S_SECOND: begin
          cnt <= cnt + 1'b1;
          if (lastStep) state <= modeQ ? S_SYNC : S_APPLY;
        end
        S_SYNC:  state <= S_APPLY;
        S_APPLY: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  sync_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncClear |-> ##2 done);

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errZero) |-> done && !busy);
endmodule

// File: rtl/clkDivCalc.sv
module clkDivCalc
  import clkDivCalcPkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int PRE_W  = 10,
  parameter int FIN_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] parentFreq,
  input  logic [FREQ_W-1:0] targetFreq,
  input  logic              ctrlMode,
  output logic              busy,
  output logic              done,
  output logic              syncClear,
  output logic              errZero,
  output logic              satFlag,
  output logic [PRE_W-1:0]  preField,
  output logic [FIN_W-1:0]  finField,
  output logic [FREQ_W-1:0] achievedFreq
);
  dpCtrlT ctl;

  clkDivControl #(.STEPS(FREQ_W)) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .targetZero (targetFreq == '0),
    .ctrlMode   (ctrlMode),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .syncClear  (syncClear),
    .errZero    (errZero)
  );

  clkDivDatapath #(.FREQ_W(FREQ_W), .PRE_W(PRE_W), .FIN_W(FIN_W)) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .parentFreq   (parentFreq),
    .targetFreq   (targetFreq),
    .satFlag      (satFlag),
    .preField     (preField),
    .finField     (finField),
    .achievedFreq (achievedFreq)
  );
endmodule

// File: tb/test_clkDivCalc.sv
module test_clkDivCalc;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 200;

  typedef struct packed {
    logic [31:0] parent;
    logic [31:0] target;
    logic        mode;
    logic [5:0]  expFin;
    logic [9:0]  expPre;
    logic [31:0] expAch;
    logic        expSat;
  } vecT;

  localparam int NVEC = 11;
  localparam vecT VECS [NVEC] = '{
    '{32'd100000000, 32'd25000000, 1'b0, 6'd3,  10'd0,    32'd25000000, 1'b0}, // exact, R1
    '{32'd100,       32'd30,       1'b1, 6'd2,  10'd0,    32'd33,       1'b0}, // rem below half, R1
    '{32'd100,       32'd40,       1'b0, 6'd2,  10'd0,    32'd33,       1'b0}, // rem exactly half rounds up, R1
    '{32'd6400,      32'd100,      1'b1, 6'd63, 10'd0,    32'd100,      1'b0}, // 64 goes to final, R2
    '{32'd6500,      32'd100,      1'b0, 6'd0,  10'd64,   32'd100,      1'b0}, // 65 goes to pre, R3
    '{32'd1000000,   32'd100,      1'b1, 6'd0,  10'd1023, 32'd976,      1'b1}, // clamp, R5
    '{32'd10,        32'd100,      1'b0, 6'd0,  10'd0,    32'd10,       1'b0}, // zero ratio forced, R4
    '{32'd10,        32'd15,       1'b0, 6'd0,  10'd0,    32'd10,       1'b0}, // zero quotient rounds to 1, R1
    '{32'd7168,      32'd7,        1'b1, 6'd0,  10'd1023, 32'd7,        1'b0}, // exactly 1024, R5
    '{32'hFFFFFFFF,  32'd1,        1'b0, 6'd0,  10'd1023, 32'd4194303,  1'b1}, // max parent, R5
    '{32'd9,         32'd2,        1'b0, 6'd4,  10'd0,    32'd1,        1'b0}  // R1 R6
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parentFreq = '0;
  logic [31:0] targetFreq = '0;
  logic        ctrlMode = 1'b0;
  logic        busy, done, syncClear, errZero, satFlag;
  logic [9:0]  preField;
  logic [5:0]  finField;
  logic [31:0] achievedFreq;

  int checks = 0;
  int errors = 0;
  int syncCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkDivCalc i_clkDivCalc (
    .clk(clk), .rstN(rstN), .start(start), .parentFreq(parentFreq),
    .targetFreq(targetFreq), .ctrlMode(ctrlMode), .busy(busy), .done(done),
    .syncClear(syncClear), .errZero(errZero), .satFlag(satFlag),
    .preField(preField), .finField(finField), .achievedFreq(achievedFreq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] p, input logic [31:0] t, input logic m);
    @(negedge clk);
    parentFreq = p;
    targetFreq = t;
    ctrlMode   = m;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  // waits for done at negedges, counting sync pulses; watchdog counted as a failure
  task automatic waitDone();
    int n;
    n = 0;
    while (!done && n < WAIT_LIMIT) begin
      if (syncClear) syncCount++;
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, "R9", "done within watchdog", n, WAIT_LIMIT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0 && done == 0 && syncClear == 0 && errZero == 0 && satFlag == 0,
          "R10", "flags after reset", {busy, done, syncClear, errZero, satFlag}, 0);
    check(preField == 0 && finField == 0 && achievedFreq == 0,
          "R10", "fields after reset", achievedFreq, 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      syncCount = 0;
      launch(VECS[i].parent, VECS[i].target, VECS[i].mode);
      check(busy == 1'b1, "R9", "busy after start", busy, 1);
      waitDone();
      check(finField == VECS[i].expFin, "R2", "final field", finField, VECS[i].expFin);
      check(preField == VECS[i].expPre, "R3", "pre field", preField, VECS[i].expPre);
      check(achievedFreq == VECS[i].expAch, "R6", "achieved", achievedFreq, VECS[i].expAch);
      check(satFlag == VECS[i].expSat, "R5", "saturation", satFlag, VECS[i].expSat);
      check(syncCount == (VECS[i].mode ? 1 : 0), "R8", "sync pulses", syncCount, VECS[i].mode);
      @(negedge clk);
      check(done == 1'b0, "R9", "done single cycle", done, 0);
    end

    // R7: zero target leaves results unchanged (last vector: fin 4, ach 1)
    launch(32'd5000, 32'd0, 1'b1);
    check(done == 1'b1, "R7", "done after zero target", done, 1);
    check(errZero == 1'b1, "R7", "error flag", errZero, 1);
    check(finField == 6'd4 && preField == 10'd0, "R7", "fields kept", finField, 4);
    check(achievedFreq == 32'd1 && satFlag == 1'b0, "R7", "achieved kept", achievedFreq, 1);
    check(busy == 1'b0, "R7", "not busy", busy, 0);

    // R7: next valid start clears error
    syncCount = 0;
    launch(32'd6400, 32'd100, 1'b0);
    check(errZero == 1'b0, "R7", "error cleared", errZero, 0);
    waitDone();
    check(finField == 6'd63, "R2", "final field after error", finField, 63);

    // R9: start while busy is ignored
    syncCount = 0;
    launch(32'd100, 32'd30, 1'b0);
    repeat (5) @(negedge clk);
    launch(32'd6500, 32'd100, 1'b1);
    waitDone();
    check(finField == 6'd2 && preField == 10'd0, "R9", "second start ignored", preField, 0);
    check(achievedFreq == 32'd33, "R9", "achieved of first request", achievedFreq, 33);
    check(syncCount == 0, "R8", "no sync from ignored start", syncCount, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule